// File: doc/BRIEF.md
# Pipelined 4:2 Compressor-Tree Unsigned Multiplier

This block multiplies two unsigned operands and returns the full double-width product. It accepts a new operand pair on every clock and delivers each result a fixed number of cycles later. A qualifier bit travels alongside the data and marks which output cycles carry a real result.

The product is formed in three steps. An AND array builds one shifted row per multiplier bit. A balanced binary tree of identical 4:2 carry-save nodes then reduces the rows to a redundant sum/carry pair. Each node is two cascaded full adders per bit. A final carry-propagate adder resolves that pair into binary. A register follows the AND array, each tree level and the final adder. With the default 16-bit operands there are three tree levels, so the latency is five cycles. The pipeline has no stall input, so a source simply presents operands with the valid strobe whenever it has them.

Top module: `mul_tree_pipe`

## Requirements
- R1: When `valid_o` is high, `product_o` equals the full-precision unsigned product of the `a_i` and `b_i` values that were presented with the corresponding `valid_i`.
- R2: `valid_o` is high in exactly the cycle that follows, by 5 clock edges, a rising edge at which `valid_i` was sampled high. It is low otherwise.
- R3: Operand pairs presented on consecutive cycles produce results on consecutive cycles, in the same order, with no bubbles.
- R4: While `rst_ni` is low, `valid_o` is 0 and `product_o` is 0.
- R5: While `valid_o` is low, `product_o` keeps the last delivered product. Operands presented with `valid_i` low have no effect on any output.
- R6: If either operand is zero, the product is zero.
- R7: For two all-ones 16-bit operands, the product is 0xFFFE0001, with no loss of upper bits.
- R8: At the tree root, whenever the root stage holds valid data, the sum and carry vectors added modulo 2^32 equal the product of the operands that entered four cycles earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair on `a_i`/`b_i` is to be multiplied |
| a_i | input | 16 | Multiplicand, unsigned |
| b_i | input | 16 | Multiplier, unsigned |
| valid_o | output | 1 | `product_o` carries a new result this cycle |
| product_o | output | 32 | Unsigned product |

## Verification
The assertions assume that `valid_i`, `a_i` and `b_i` hold known values at every clock edge after reset is released. The latency, product and root checks compare against values that lie up to five edges in the past, and these are only trusted once that many edges have passed since reset. The stimulus therefore drives defined values at all times, including idle cycles, where it drives arbitrary defined operands with `valid_i` low. It holds reset across several edges and changes inputs only on the falling clock edge.

// File: rtl/mul_tree_pkg.sv
package mul_tree_pkg;
  localparam int unsigned OP_W_DEF = 16;
endpackage

// File: rtl/mul_pp_gen.sv
module mul_pp_gen #(
  parameter int unsigned OW = 16,
  localparam int unsigned PW = 2 * OW
) (
  input  logic [OW-1:0] a_i,
  input  logic [OW-1:0] b_i,
  output logic [PW-1:0] pp_o [OW]
);
  for (genvar i = 0; i < OW; i++) begin : g_row
    assign pp_o[i] = PW'(a_i & {OW{b_i[i]}}) << i;
  end
endmodule

// File: rtl/mul_csa42.sv
// 4:2 compressor: two cascaded full adders per bit slice.
module mul_csa42 #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] in0_i,
  input  logic [W-1:0] in1_i,
  input  logic [W-1:0] in2_i,
  input  logic [W-1:0] in3_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] carry_o
);
  logic [W-1:0] s1, m1, ci, m2;

  // first full adder
  assign s1 = in0_i ^ in1_i ^ in2_i;
  assign m1 = (in0_i & in1_i) | (in0_i & in2_i) | (in1_i & in2_i);
  // intermediate carry feeds the next slice; top bit dropped
  assign ci = m1 << 1;
  // second full adder
  assign sum_o   = s1 ^ in3_i ^ ci;
  assign m2      = (s1 & in3_i) | (s1 & ci) | (in3_i & ci);
  assign carry_o = m2 << 1;
endmodule

// File: rtl/mul_cpa.sv
module mul_cpa #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  assign sum_o = x_i + y_i;
endmodule

// File: rtl/mul_tree_pipe.sv
module mul_tree_pipe
  import mul_tree_pkg::*;
#(
  parameter int unsigned OP_W = OP_W_DEF,
  localparam int unsigned PW     = 2 * OP_W,
  localparam int unsigned LEVELS = $clog2(OP_W) - 1,
  localparam int unsigned LAT    = LEVELS + 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [OP_W-1:0] a_i,
  input  logic [OP_W-1:0] b_i,
  output logic            valid_o,
  output logic [PW-1:0]   product_o
);
  // level 0 holds the partial products; level l holds OP_W>>l vectors
  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int unsigned NV = OP_W >> l;
    logic [PW-1:0] d [NV];
    logic [PW-1:0] q [NV];
    logic          v_d, v_q;

    if (l == 0) begin : g_pp
      mul_pp_gen #(.OW(OP_W)) u_pp (
        .a_i  (a_i),
        .b_i  (b_i),
        .pp_o (d)
      );
      assign v_d = valid_i;
    end else begin : g_red
      for (genvar k = 0; k < NV / 2; k++) begin : g_node
        mul_csa42 #(.W(PW)) u_node (
          .in0_i   (g_lvl[l-1].q[4*k]),
          .in1_i   (g_lvl[l-1].q[4*k+1]),
          .in2_i   (g_lvl[l-1].q[4*k+2]),
          .in3_i   (g_lvl[l-1].q[4*k+3]),
          .sum_o   (d[2*k]),
          .carry_o (d[2*k+1])
        );
      end
      assign v_d = g_lvl[l-1].v_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q <= 1'b0;
        for (int i = 0; i < int'(NV); i++) q[i] <= '0;
      end else begin
        v_q <= v_d;
        if (v_d) begin
          for (int i = 0; i < int'(NV); i++) q[i] <= d[i];
        end
      end
    end
  end

  logic [PW-1:0] cpa_sum;

  mul_cpa #(.W(PW)) u_cpa (
    .x_i   (g_lvl[LEVELS].q[0]),
    .y_i   (g_lvl[LEVELS].q[1]),
    .sum_o (cpa_sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      product_o <= '0;
    end else begin
      valid_o <= g_lvl[LEVELS].v_q;
      if (g_lvl[LEVELS].v_q) product_o <= cpa_sum;
    end
  end

  // assertion support: edges seen since reset, saturating at LAT
  localparam int unsigned CW = $clog2(LAT + 1);
  logic [CW-1:0] seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                seen_q <= '0;
    else if (seen_q != CW'(LAT)) seen_q <= seen_q + 1'b1;
  end

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q == CW'(LAT)) |-> (valid_o == $past(valid_i, LAT)));

  // R1
  product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q == CW'(LAT)) && valid_o) |->
      (product_o == $past(PW'(a_i) * PW'(b_i), LAT)));

  // R8
  root_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q >= CW'(LEVELS + 1)) && g_lvl[LEVELS].v_q) |->
      (PW'(g_lvl[LEVELS].q[0] + g_lvl[LEVELS].q[1])
        == $past(PW'(a_i) * PW'(b_i), LEVELS + 1)));

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((seen_q != '0) && !valid_o) |-> $stable(product_o));
endmodule

// File: tb/mul_tree_pipe_bench.sv
module mul_tree_pipe_bench;
  localparam int LAT = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] a_i = '0;
  logic [15:0] b_i = '0;
  logic        valid_o;
  logic [31:0] product_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [31:0] exp_q [$];
  int          iss_q [$];
  string       tag_q [$];
  logic [31:0] last_prod = '0;

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  mul_tree_pipe u_mul_tree_pipe (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .valid_i   (valid_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .valid_o   (valid_o),
    .product_o (product_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, expv, cyc);
    end
  endtask

  task automatic send(input logic [15:0] a, input logic [15:0] b, input string tag);
    @(negedge clk);
    a_i = a; b_i = b; valid_i = 1'b1;
    exp_q.push_back(32'(a) * 32'(b));
    iss_q.push_back(cyc);
    tag_q.push_back(tag);
  endtask

  // idle cycles with junk operands: must be ignored (R5)
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0;
      a_i = 16'($urandom); b_i = 16'($urandom);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_n) begin
      // R4
      chk(valid_o == 1'b0, "R4 valid", 32'(valid_o), 32'h0);
      chk(product_o == '0, "R4 product", product_o, 32'h0);
    end else if (valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 spurious valid", 32'(valid_o), 32'h0);
      end else begin
        logic [31:0] e;
        int    iss;
        string tg;
        e = exp_q.pop_front();
        iss = iss_q.pop_front();
        tg = tag_q.pop_front();
        chk(product_o == e, tg, product_o, e);
        chk(cyc - iss == LAT, (tg == "R3") ? "R3 latency" : "R2 latency",
            32'(cyc - iss), 32'(LAT));
        last_prod = product_o;
      end
    end else begin
      // R5: holds last result while not valid
      chk(product_o == last_prod, "R5 hold", product_o, last_prod);
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    // R6 zero operands
    send(16'h0000, 16'h1234, "R6");
    send(16'hBEEF, 16'h0000, "R6");
    send(16'h0000, 16'h0000, "R6");
    idle(2);
    // R7 all ones and edges
    send(16'hFFFF, 16'hFFFF, "R7");
    idle(1);
    send(16'hFFFF, 16'h0001, "R7");
    send(16'h8000, 16'h8000, "R7");
    idle(7);
    // R1/R8 random with gaps
    for (int i = 0; i < 60; i++) begin
      send(16'($urandom), 16'($urandom), "R1");
      idle(int'($urandom_range(0, 3)));
    end
    // R3 back-to-back burst
    for (int i = 0; i < 40; i++) send(16'($urandom), 16'($urandom), "R3");
    idle(1);
    for (int i = 0; i < 16; i++) send(16'(1) << i, 16'hFFFF >> i, "R3");
    idle(1);
    // drain with watchdog
    begin
      int w = 0;
      while (exp_q.size() != 0 && w < 1000) begin
        @(negedge clk);
        w++;
      end
      if (exp_q.size() != 0)
        chk(1'b0, "R2 watchdog drain", 32'(exp_q.size()), 32'h0);
    end
    idle(4);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule